// File: doc/BRIEF.md
# Accumulator Machine Instruction-Cycle Sequencer

This block is the control unit and datapath of a small multicycle accumulator processor. It moves every instruction through four major phases, each marked by a two-bit cycle code on an output pin: instruction fetch, operand resolution, execution and an interrupt check. Inside it sit the program counter, the memory address and memory buffer registers, the instruction register and the accumulator. It drives one synchronous single-port memory that returns read data on the clock edge after a read strobe.

Each instruction word is 16 bits. Bits [15:14] hold the addressing mode: 00 immediate, 01 direct, 10 indirect, and 11, which together with the jump opcode means "return from interrupt". Mode 11 with any other opcode behaves as direct. Bits [13:12] hold the opcode: 00 load, 01 add, 10 store, 11 jump. Bits [11:0] hold the address or immediate field. One level-sensitive interrupt request sends the machine to a fixed service-routine address. The return address is kept in a four-entry hardware stack, and further requests are masked until the routine returns.

The memory pins are a plain request/response port, not a stream: the memory must accept a read or write in the cycle it is strobed and never stall. There is no back-pressure.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous reset, held for at least one rising edge, leaves the cycle code at 00, the program counter at 0, the accumulator at 0 and the interrupt mask clear.
- R2: The cycle code only ever holds its value or steps in the order 00, 01, 10, 11, and from 11 it always goes to 00. An immediate load or add shows 01 four edges after its fetch begins, 10 at edge five, 11 at edge six and 00 at edge seven.
- R3: Fetch reads memory at the program counter and increments the counter by one. The new value is visible three edges after fetch begins. Memory reads occur only while the cycle code is 00 or 01.
- R4: With immediate mode (bits [15:14] = 00), no memory read is made while the code is 01. The 12-bit field, zero-extended, is the operand.
- R5: With direct mode (01), one read is made at the address field, and that word is the operand.
- R6: With indirect mode (10), a read at the address field yields a pointer. Its low 12 bits replace the address field, and resolution then continues as in direct mode. A load thus reads the field address and then the pointer address.
- R7: Load (opcode 00) copies the operand to the accumulator. Add (01) adds it modulo 2^16.
- R8: Jump (opcode 11) loads the program counter with the resolved target in place of the incremented value. Store (opcode 10) issues exactly one write strobe, during code 10, to the resolved address, with the accumulator as data.
- R9: The interrupt request is sampled only in the cycle where the code is 11. If the request is high and not masked, the return address is saved, the counter becomes the service address (0x100 by default) and the mask is set. Otherwise the next fetch uses the normal counter.
- R10: While the mask is set, a held request has no effect on the program counter.
- R11: A return (mode 11 with jump) restores the most recently saved address and clears the mask. With nothing saved it sets the counter to 0.
- R12: A program at 0x3F0 that loads 0xFF0, adds 0xFF1 and stores to 0xFF2, with 5 and 7 in the sources, leaves 12 at 0xFF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on the next edge |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data registered by the memory |
| phase | output | 2 | Instruction cycle code |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| irq_masked | output | 1 | Interrupt mask (service routine running) |

## Verification
Every result has a fixed latency in clock edges counted from the edge that starts a fetch. Fetch takes four edges and the counter increments at edge three. An immediate instruction, a direct store or a direct jump completes in seven edges, a direct load or add in nine, an indirect jump in eleven and an indirect load in thirteen. An interrupt takes effect on the seventh edge of the instruction during which it was raised, so the new counter and mask are visible then. The bench advances by exactly these edge counts, samples on the falling edge that follows, and records every memory read and write address so that the access order of each addressing mode can be compared.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_OPND  = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    AM_IMM = 2'b00,
    AM_DIR = 2'b01,
    AM_IND = 2'b10,
    AM_RET = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_JUMP  = 2'b11
  } opcode_e;

  // micro-steps inside the four major phases
  typedef enum logic [3:0] {
    S_F_MAR, S_F_RD, S_F_MBR, S_F_IR,
    S_D_START, S_D_PRD, S_D_PMBR, S_D_PFIX, S_D_ORD, S_D_OMBR,
    S_E_RUN,
    S_I_CHK
  } ustep_e;

  function automatic phase_e phase_of(ustep_e s);
    case (s)
      S_F_MAR, S_F_RD, S_F_MBR, S_F_IR:                       return PH_FETCH;
      S_D_START, S_D_PRD, S_D_PMBR, S_D_PFIX, S_D_ORD, S_D_OMBR: return PH_OPND;
      S_E_RUN:                                                return PH_EXEC;
      default:                                                return PH_INTR;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  logic       masked,
  input  logic [1:0] mode,
  input  logic [1:0] opc,
  output ustep_e     step,
  output logic       mar_from_pc,
  output logic       mar_from_ir,
  output logic       rd_strobe,
  output logic       mbr_ld,
  output logic       pc_inc,
  output logic       ir_ld,
  output logic       ir_fix,
  output logic       exec_en,
  output logic       intr_take
);

  ustep_e step_nx;
  logic   needs_data;
  logic   is_ind;

  assign is_ind     = (mode == AM_IND);
  assign needs_data = ((opc == OP_LOAD) || (opc == OP_ADD)) && (mode != AM_IMM);

  always_comb begin
    step_nx = step;
    case (step)
      S_F_MAR:   step_nx = S_F_RD;
      S_F_RD:    step_nx = S_F_MBR;
      S_F_MBR:   step_nx = S_F_IR;
      S_F_IR:    step_nx = S_D_START;
      S_D_START: begin
        if (is_ind)          step_nx = S_D_PRD;
        else if (needs_data) step_nx = S_D_ORD;
        else                 step_nx = S_E_RUN;
      end
      S_D_PRD:   step_nx = S_D_PMBR;
      S_D_PMBR:  step_nx = S_D_PFIX;
      S_D_PFIX:  step_nx = S_D_START;
      S_D_ORD:   step_nx = S_D_OMBR;
      S_D_OMBR:  step_nx = S_E_RUN;
      S_E_RUN:   step_nx = S_I_CHK;
      S_I_CHK:   step_nx = S_F_MAR;
      default:   step_nx = S_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= S_F_MAR;
    else     step <= step_nx;
  end

  always_comb begin
    mar_from_pc = (step == S_F_MAR);
    mar_from_ir = (step == S_D_START) && (is_ind || needs_data);
    rd_strobe   = (step == S_F_RD) || (step == S_D_PRD) || (step == S_D_ORD);
    mbr_ld      = (step == S_F_MBR) || (step == S_D_PMBR) || (step == S_D_OMBR);
    pc_inc      = (step == S_F_MBR);
    ir_ld       = (step == S_F_IR);
    ir_fix      = (step == S_D_PFIX);
    exec_en     = (step == S_E_RUN);
    intr_take   = (step == S_I_CHK) && irq && !masked;
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]    opc,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          acc_we
);

  always_comb begin
    result = acc;
    acc_we = 1'b0;
    case (opc)
      OP_LOAD: begin result = operand;       acc_we = 1'b1; end
      OP_ADD:  begin result = acc + operand; acc_we = 1'b1; end
      default: begin result = acc;           acc_we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/acc_cpu_rstack.sv
module acc_cpu_rstack #(
  parameter int AW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] rp;
  logic [CW-1:0] fill;

  assign rp       = wp - PW'(1);
  assign top_addr = (fill == '0) ? '0 : slot[rp];

  // circular storage: a push when full overwrites the oldest entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp == PW'(i))) slot[i] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
    end else if (push) begin
      wp <= wp + PW'(1);
      if (fill != FULL) fill <= fill + CW'(1);
    end else if (pop && (fill != '0)) begin
      wp   <= rp;
      fill <= fill - CW'(1);
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int          AW          = 12,
  parameter int          STACK_DEPTH = 4,
  parameter int unsigned ISR_ADDR    = 'h100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [AW+3:0]      mem_wdata,
  input  logic [AW+3:0]      mem_rdata,
  output logic [1:0]         phase,
  output logic [AW-1:0]      pc_out,
  output logic [AW+3:0]      acc_out,
  output logic               irq_masked
);

  localparam int DW = AW + 4;
  localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);

  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mbr, ir, ac;
  logic          masked;

  logic [1:0]    ir_mode, ir_opc;
  logic [AW-1:0] ir_field;

  assign ir_mode  = ir[DW-1 -: 2];
  assign ir_opc   = ir[AW+1:AW];
  assign ir_field = ir[AW-1:0];

  ustep_e step;
  logic   mar_from_pc, mar_from_ir, rd_strobe, mbr_ld, pc_inc;
  logic   ir_ld, ir_fix, exec_en, intr_take;

  acc_cpu_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .masked      (masked),
    .mode        (ir_mode),
    .opc         (ir_opc),
    .step        (step),
    .mar_from_pc (mar_from_pc),
    .mar_from_ir (mar_from_ir),
    .rd_strobe   (rd_strobe),
    .mbr_ld      (mbr_ld),
    .pc_inc      (pc_inc),
    .ir_ld       (ir_ld),
    .ir_fix      (ir_fix),
    .exec_en     (exec_en),
    .intr_take   (intr_take)
  );

  logic          is_store, is_jump, is_ret;
  logic [DW-1:0] operand, alu_res;
  logic          alu_we;

  assign is_store = (ir_opc == OP_STORE);
  assign is_jump  = (ir_opc == OP_JUMP) && (ir_mode != AM_RET);
  assign is_ret   = (ir_opc == OP_JUMP) && (ir_mode == AM_RET);
  assign operand  = (ir_mode == AM_IMM) ? DW'(ir_field) : mbr;

  acc_cpu_alu #(.DW(DW)) u_alu (
    .opc     (ir_opc),
    .acc     (ac),
    .operand (operand),
    .result  (alu_res),
    .acc_we  (alu_we)
  );

  logic          stk_pop;
  logic [AW-1:0] stk_top;

  assign stk_pop = exec_en && is_ret;

  acc_cpu_rstack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (intr_take),
    .pop       (stk_pop),
    .push_addr (pc),
    .top_addr  (stk_top)
  );

  // address register and buffer register
  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mbr <= '0;
    end else begin
      if (mar_from_pc)      mar <= pc;
      else if (mar_from_ir) mar <= ir_field;
      if (mbr_ld) mbr <= mem_rdata;
    end
  end

  // instruction register; indirect resolution rewrites it as direct
  always_ff @(posedge clk) begin
    if (rst)         ir <= '0;
    else if (ir_ld)  ir <= mbr;
    else if (ir_fix) ir <= {AM_DIR, ir_opc, mbr[AW-1:0]};
  end

  // program counter and interrupt mask
  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      masked <= 1'b0;
    end else if (intr_take) begin
      pc     <= ISR_VEC;
      masked <= 1'b1;
    end else if (pc_inc) begin
      pc <= pc + AW'(1);
    end else if (exec_en && is_jump) begin
      pc <= ir_field;
    end else if (stk_pop) begin
      pc     <= stk_top;
      masked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    ac <= '0;
    else if (exec_en && alu_we) ac <= alu_res;
  end

  assign mem_rd     = rd_strobe;
  assign mem_wr     = exec_en && is_store;
  assign mem_addr   = (exec_en && is_store) ? ir_field : mar;
  assign mem_wdata  = ac;
  assign phase      = phase_of(step);
  assign pc_out     = pc;
  assign acc_out    = ac;
  assign irq_masked = masked;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int          AW       = 12,
  parameter int unsigned ISR_ADDR = 'h100
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [1:0]    phase,
  input logic [AW-1:0] pc_out,
  input logic          irq_masked
);

  localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (phase == 2'b00 && pc_out == '0 && !irq_masked));

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == $past(phase) || phase == $past(phase) + 2'd1));

  assert_read_phase_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (phase == 2'b00 || phase == 2'b01));

  assert_write_exec_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (phase == 2'b10 && !mem_rd));

  assert_mask_from_check_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_masked) |-> ($past(phase) == 2'b11 && pc_out == ISR_VEC));

  assert_masked_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11 && irq_masked && irq) |=> (pc_out == $past(pc_out)));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.AW(AW), .ISR_ADDR(ISR_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .phase      (phase),
  .pc_out     (pc_out),
  .irq_masked (irq_masked)
);

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0]    phase;
  logic [AW-1:0] pc_out;
  logic [DW-1:0] acc_out;
  logic          irq_masked;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core dut (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .phase      (phase),
    .pc_out     (pc_out),
    .acc_out    (acc_out),
    .irq_masked (irq_masked)
  );

  // memory model with a loader port and access log
  logic [DW-1:0] mem [0:4095];
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] rd_log [0:15];
  int            rd_n, dec_rd, wr_n;
  logic [AW-1:0] wr_last;

  always @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (rst) begin
      rd_n <= 0; dec_rd <= 0; wr_n <= 0; wr_last <= '0;
    end else begin
      if (mem_rd) begin
        if (rd_n < 16) rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
        if (phase == 2'b01) dec_rd <= dec_rd + 1;
      end
      if (mem_wr) begin
        wr_n <= wr_n + 1;
        wr_last <= mem_addr;
      end
    end
  end

  function automatic logic [DW-1:0] ins(input logic [1:0] m, input logic [1:0] op,
                                        input logic [AW-1:0] a);
    return {m, op, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    irq = 1'b0;
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b00, 12'h0AB));
    release_reset();
    run(7);
    check("R7 imm load before reset", acc_out, 16'h00AB);
    hold_reset();
    @(negedge clk);
    check("R1 phase in reset", phase, 2'b00);
    check("R1 pc in reset", pc_out, 0);
    check("R1 acc in reset", acc_out, 0);
    check("R1 mask in reset", irq_masked, 0);
  endtask

  task automatic t_phase_imm();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b00, 12'h123));
    release_reset();
    check("R2 code at start", phase, 2'b00);
    run(3);
    check("R3 pc incremented", pc_out, 1);
    run(1);
    check("R2 code 01", phase, 2'b01);
    run(1);
    check("R2 code 10", phase, 2'b10);
    run(1);
    check("R2 code 11", phase, 2'b11);
    check("R4 imm operand in acc", acc_out, 16'h0123);
    run(1);
    check("R2 code back to 00", phase, 2'b00);
    check("R4 no operand-phase read", dec_rd, 0);
    check("R3 fetch address", rd_log[0], 12'h000);
  endtask

  task automatic t_direct_add();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b00, 12'h005));
    poke(12'h001, ins(2'b01, 2'b01, 12'h020));
    poke(12'h020, 16'd7);
    release_reset();
    run(16);
    check("R7 direct add", acc_out, 16'd12);
    check("R5 read count", rd_n, 3);
    check("R5 operand address", rd_log[2], 12'h020);
  endtask

  task automatic t_indirect_load();
    hold_reset();
    poke(12'h000, ins(2'b10, 2'b00, 12'h030));
    poke(12'h030, 16'h0040);
    poke(12'h040, 16'hBEEF);
    release_reset();
    run(13);
    check("R6 indirect load value", acc_out, 16'hBEEF);
    check("R6 pointer read address", rd_log[1], 12'h030);
    check("R6 data read address", rd_log[2], 12'h040);
    check("R2 indirect ends in fetch", phase, 2'b00);
  endtask

  task automatic t_add_wrap();
    hold_reset();
    poke(12'h000, ins(2'b01, 2'b00, 12'h080));
    poke(12'h001, ins(2'b00, 2'b01, 12'h001));
    poke(12'h080, 16'hFFFF);
    release_reset();
    run(9);
    check("R5 direct load", acc_out, 16'hFFFF);
    run(7);
    check("R7 add wraps", acc_out, 16'h0000);
  endtask

  task automatic t_ref_program();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b11, 12'h3F0));
    poke(12'h3F0, ins(2'b01, 2'b00, 12'hFF0));
    poke(12'h3F1, ins(2'b01, 2'b01, 12'hFF1));
    poke(12'h3F2, ins(2'b01, 2'b10, 12'hFF2));
    poke(12'hFF0, 16'd5);
    poke(12'hFF1, 16'd7);
    poke(12'hFF2, 16'd0);
    release_reset();
    run(7);
    check("R8 jump target", pc_out, 12'h3F0);
    run(25);
    check("R12 result at FF2", mem[12'hFF2], 16'd12);
    check("R8 single store write", wr_n, 1);
    check("R8 store address", wr_last, 12'hFF2);
    check("R12 pc after program", pc_out, 12'h3F3);
  endtask

  task automatic t_indirect_jump();
    hold_reset();
    poke(12'h000, ins(2'b10, 2'b11, 12'h050));
    poke(12'h050, 16'h0123);
    release_reset();
    run(11);
    check("R8 indirect jump", pc_out, 12'h123);
  endtask

  task automatic t_interrupt();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b00, 12'h001));
    poke(12'h100, ins(2'b00, 2'b00, 12'h055));
    poke(12'h101, ins(2'b11, 2'b11, 12'h000));
    irq = 1'b1;
    release_reset();
    run(6);
    check("R9 instruction finishes first", acc_out, 16'h0001);
    run(1);
    check("R9 vector taken", pc_out, 12'h100);
    check("R9 mask set", irq_masked, 1);
    run(7);
    check("R10 held request ignored", pc_out, 12'h101);
    check("R10 routine ran", acc_out, 16'h0055);
    irq = 1'b0;
    run(7);
    check("R11 return address", pc_out, 12'h001);
    check("R11 mask cleared", irq_masked, 0);
  endtask

  task automatic t_irq_early_drop();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b00, 12'h001));
    irq = 1'b1;
    release_reset();
    run(6);
    irq = 1'b0;
    run(1);
    check("R9 request outside code 11 ignored", pc_out, 12'h001);
    check("R9 mask stays clear", irq_masked, 0);
  endtask

  task automatic t_empty_return();
    hold_reset();
    poke(12'h000, ins(2'b00, 2'b11, 12'h010));
    poke(12'h010, ins(2'b11, 2'b11, 12'h000));
    release_reset();
    run(7);
    check("R8 imm jump", pc_out, 12'h010);
    run(7);
    check("R11 empty return gives zero", pc_out, 12'h000);
  endtask

  initial begin
    t_reset();
    t_phase_imm();
    t_direct_add();
    t_indirect_load();
    t_add_wrap();
    t_ref_program();
    t_indirect_jump();
    t_interrupt();
    t_irq_early_drop();
    t_empty_return();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule